// File: doc/BRIEF.md
# Banked Instruction Fetch Aligner

This block hands the decoder a full group of instruction words that begins at any instruction address, including an address near the end of a cache line. Each line holds one fetch group's worth of words. Lines are spread over two storage banks: lines with an even line index go to one bank and lines with an odd index go to the other. Because of this, the line holding the start address and the line after it can always be read in the same cycle.

The start address is an instruction index, not a byte address. Its low bits give the slot offset inside the line, and the remaining bits give the line index. The bottom bit of the line index decides which bank supplies the first line. A rotator then takes the words from offset onward in the first line, follows them with the leading words of the next line, and presents the result in program order.

The result appears one clock after the request. Both banks are synchronous RAMs, and their read registers form the pipeline stage. A small two-state machine sets the per-slot valid flags:

- ST_EMPTY: no group is presented. The transition to ST_FULL happens when a request is accepted.
- ST_FULL: a group is presented. The machine stays in ST_FULL if another request arrives, and returns to ST_EMPTY if none does.

The banks are filled through a load port that writes one word per cycle. Tag checks, misses and refills are not part of this block.

Top module: `fetch_aligner`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no request, all slot valid flags are 0 and the group data is all zero.
- R2: A request accepted at a rising clock edge makes all slot valid flags 1 after that edge. A cycle with no request leaves every flag 0 after the next edge.
- R3: For a start address whose slot offset (the low log2(SLOTS) bits) is 0, output slot i (bits [i*WORD_W +: WORD_W]) holds the word stored at address start+i.
- R4: For a nonzero slot offset, output slot i holds the word at start+i. The words of the next line follow the tail of the current line, in program order.
- R5: When the start line index is odd, the slots past the end of the line come from the even bank at line index plus one.
- R6: Addresses wrap at the top of the address space. A group that starts in the last line continues with line 0, so slot i holds the word at (start+i) mod 2^PC_W.
- R7: The slot valid flags are either all 1 or all 0. When they are 0, the group data is zero.
- R8: A load-port write of a word to an address changes the word returned for that address in later fetches. Other addresses are not affected.
- R9: Requests on consecutive cycles each produce their own group, one cycle later, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Fetch request strobe |
| req_pc | input | PC_W | Start instruction address of the group |
| ld_en | input | 1 | Load-port write enable |
| ld_addr | input | PC_W | Instruction address to write |
| ld_data | input | WORD_W | Instruction word to write |
| grp_vld | output | SLOTS | Per-slot valid flags |
| grp_data | output | SLOTS*WORD_W | Aligned group, slot i at bits [i*WORD_W +: WORD_W] |

## Verification
The hardest case to reach is a group that starts in the very last line. It needs the even bank's read index to wrap to zero at the same time as a rotate that spans both lines. Random addresses seldom land there. The bench reaches it by sweeping every start address in a small configuration (256 instructions), first with idle cycles between requests and then back to back in reverse order. Every word is preloaded with a value unique to its address, so any wrong bank, index or rotate shows up as a mismatch.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } fa_state_t;
endpackage

// File: rtl/fa_line_bank.sv
module fa_line_bank #(
    parameter int IDX_W  = 5,
    parameter int SLOTS  = 4,
    parameter int WORD_W = 32,
    parameter int OFF_W  = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [OFF_W-1:0]        wr_slot,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    rd_en,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [SLOTS*WORD_W-1:0] rd_line
);
    localparam int DEPTH = 1 << IDX_W;

    logic [SLOTS*WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx][wr_slot*WORD_W +: WORD_W] <= wr_data;
        end
        if (rd_en) begin
            rd_line <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/fa_rotator.sv
module fa_rotator #(
    parameter int SLOTS  = 4,
    parameter int WORD_W = 32,
    parameter int OFF_W  = $clog2(SLOTS)
) (
    input  logic [SLOTS*WORD_W-1:0] first_line,
    input  logic [SLOTS*WORD_W-1:0] next_line,
    input  logic [OFF_W-1:0]        amt,
    output logic [SLOTS*WORD_W-1:0] group
);
    localparam int SEL_W = OFF_W + 1;

    logic [2*SLOTS*WORD_W-1:0] joined;
    assign joined = {next_line, first_line};

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [SEL_W-1:0] sel;
        assign sel = SEL_W'(i) + SEL_W'(amt);
        assign group[i*WORD_W +: WORD_W] = joined[sel*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int SLOTS  = 4,
    parameter int WORD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [PC_W-1:0]         req_pc,
    input  logic                    ld_en,
    input  logic [PC_W-1:0]         ld_addr,
    input  logic [WORD_W-1:0]       ld_data,
    output logic [SLOTS-1:0]        grp_vld,
    output logic [SLOTS*WORD_W-1:0] grp_data
);
    localparam int OFF_W  = $clog2(SLOTS);
    localparam int LINE_W = PC_W - OFF_W;
    localparam int BIDX_W = LINE_W - 1;
    localparam int GRP_W  = SLOTS * WORD_W;

    fa_state_t state_q, state_d;

    logic [LINE_W-1:0] start_line;
    logic [BIDX_W-1:0] bank_idx  [2];
    logic [GRP_W-1:0]  bank_line [2];
    logic              start_odd_q;
    logic [OFF_W-1:0]  off_q;
    logic [GRP_W-1:0]  first_line, next_line, rotated;

    assign start_line = req_pc[PC_W-1:OFF_W];
    // even bank holds line A (A even) or line A+1 (A odd); index wraps
    assign bank_idx[0] = start_line[LINE_W-1:1] + BIDX_W'(start_line[0]);
    assign bank_idx[1] = start_line[LINE_W-1:1];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic wr_here;
        assign wr_here = ld_en && (ld_addr[OFF_W] == 1'(b));
        fa_line_bank #(
            .IDX_W (BIDX_W),
            .SLOTS (SLOTS),
            .WORD_W(WORD_W),
            .OFF_W (OFF_W)
        ) u_bank (
            .clk    (clk),
            .wr_en  (wr_here),
            .wr_idx (ld_addr[PC_W-1:OFF_W+1]),
            .wr_slot(ld_addr[OFF_W-1:0]),
            .wr_data(ld_data),
            .rd_en  (req_valid),
            .rd_idx (bank_idx[b]),
            .rd_line(bank_line[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_odd_q <= 1'b0;
            off_q       <= '0;
        end else if (req_valid) begin
            start_odd_q <= start_line[0];
            off_q       <= req_pc[OFF_W-1:0];
        end
    end

    assign first_line = start_odd_q ? bank_line[1] : bank_line[0];
    assign next_line  = start_odd_q ? bank_line[0] : bank_line[1];

    fa_rotator #(
        .SLOTS (SLOTS),
        .WORD_W(WORD_W),
        .OFF_W (OFF_W)
    ) u_rot (
        .first_line(first_line),
        .next_line (next_line),
        .amt       (off_q),
        .group     (rotated)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = req_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = req_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        grp_vld  = '0;
        grp_data = '0;
        unique case (state_q)
            ST_EMPTY: begin
                grp_vld  = '0;
                grp_data = '0;
            end
            ST_FULL: begin
                grp_vld  = '1;
                grp_data = rotated;
            end
            default: begin
                grp_vld  = '0;
                grp_data = '0;
            end
        endcase
    end

    // R2
    req_latency_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (grp_vld == '1));

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (grp_vld == '0));

    // R7
    all_or_none_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_vld == '0) || (grp_vld == '1));

    // R7
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_vld == '0) |-> (grp_data == '0));

    // R6
    wrap_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && start_line == '1) |-> (bank_idx[0] == '0));
endmodule

// File: tb/fetch_aligner_bench.sv
module fetch_aligner_bench;
    localparam int PC_W   = 8;
    localparam int SLOTS  = 4;
    localparam int WORD_W = 32;
    localparam int NADDR  = 1 << PC_W;
    localparam time CLK_PERIOD = 10ns;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic [PC_W-1:0]         req_pc = '0;
    logic                    ld_en = 1'b0;
    logic [PC_W-1:0]         ld_addr = '0;
    logic [WORD_W-1:0]       ld_data = '0;
    logic [SLOTS-1:0]        grp_vld;
    logic [SLOTS*WORD_W-1:0] grp_data;

    logic [WORD_W-1:0] shadow [NADDR];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fetch_aligner #(.PC_W(PC_W), .SLOTS(SLOTS), .WORD_W(WORD_W)) u_fetch_aligner (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pc(req_pc),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .grp_vld(grp_vld), .grp_data(grp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WORD_W-1:0] word_of(int a);
        return {8'hA5, 8'(a * 7), 8'(a), 8'(~a)};
    endfunction

    function automatic string tag_of(int pc);
        if ((pc >> 2) == (NADDR / SLOTS) - 1) return "R6";
        if (((pc >> 2) & 1) == 1)             return "R5";
        if ((pc % SLOTS) != 0)                return "R4";
        return "R3";
    endfunction

    task automatic check_idle(string tag);
        checks++;
        if (grp_vld !== '0 || grp_data !== '0) begin
            errors++;
            $display("FAIL %s idle: vld=%b data=%h expected vld=0 data=0", tag, grp_vld, grp_data);
        end
    endtask

    task automatic check_group(int pc, string tag);
        logic [SLOTS*WORD_W-1:0] exp;
        for (int i = 0; i < SLOTS; i++) exp[i*WORD_W +: WORD_W] = shadow[(pc + i) % NADDR];
        checks++;
        if (grp_vld !== '1 || grp_data !== exp) begin
            errors++;
            $display("FAIL %s pc=%0d: vld=%b data=%h expected vld=%b data=%h",
                     tag, pc, grp_vld, grp_data, {SLOTS{1'b1}}, exp);
        end
    endtask

    task automatic load_word(int a, logic [WORD_W-1:0] d);
        ld_en = 1'b1; ld_addr = PC_W'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        shadow[a] = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        for (int a = 0; a < NADDR; a++) load_word(a, word_of(a));

        // single requests separated by an idle cycle
        for (int pc = 0; pc < NADDR; pc++) begin
            req_valid = 1'b1; req_pc = PC_W'(pc);
            @(negedge clk);
            req_valid = 1'b0;
            check_group(pc, tag_of(pc));
            @(negedge clk);
            check_idle("R2");
        end

        // back-to-back stream, reverse order (R9)
        req_valid = 1'b1; req_pc = PC_W'(NADDR - 1);
        for (int pc = NADDR - 1; pc >= 0; pc--) begin
            @(negedge clk);
            if (pc > 0) req_pc = PC_W'(pc - 1);
            else        req_valid = 1'b0;
            check_group(pc, "R9");
        end
        @(negedge clk);
        check_idle("R2");

        // overwrite one word and refetch around it (R8)
        load_word(6, 32'hDEAD_BEEF);
        for (int pc = 2; pc <= 8; pc++) begin
            req_valid = 1'b1; req_pc = PC_W'(pc);
            @(negedge clk);
            req_valid = 1'b0;
            check_group(pc, "R8");
        end
        @(negedge clk);
        check_idle("R7");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule